// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between DMA-capable devices and the system bus. A device presents a 24-bit DMA address. The unit maps that address through a table of 2048 page descriptors, one descriptor for each 8 KB page, and returns a 32-bit system bus address. Address bits 23..13 pick the descriptor and bits 12..0 pass through as the offset within the page.

Along with a successful translation, the unit passes out two attributes from the descriptor: cache inhibit and full-block transfer. If the translation cannot be made, it reports a fault cause instead. The causes are an unused page, an illegal descriptor code, and a write to a write-protected page.

A device with fewer than 24 address lines is folded onto the top of the DMA space. The CPU loads and inspects the table through a word-wide port indexed by entry number.

Top module: `dma_xlate_unit`

## Requirements
- R1: While reset is held and after its release, `rsp_valid_o` is 0 and `rsp_fault_o` is 00 until a request is accepted.
- R2: A request sampled at a rising edge with `req_valid_i`=1 gives `rsp_valid_o`=1 in the following cycle only. With no request, the next cycle has `rsp_valid_o`=0 and `rsp_fault_o`=00.
- R3: The descriptor fields are: bits 31..13 page frame, bits 12..7 spare, bit 6 cache inhibit, bit 5 full block, bit 4 modified, bit 3 used, bit 2 write protect, bits 1..0 type. For type 01 with no protect violation, the response is `rsp_addr_o` = {frame, offset}, `rsp_ci_o` = bit 6, `rsp_bx_o` = bit 5, and `rsp_fault_o` = 00.
- R4: A descriptor of type 00 gives fault 01 (unused page) for both reads and writes.
- R5: A descriptor of type 10 or 11 gives fault 10 (illegal code), whatever its other bits hold. This fault wins over write protect.
- R6: On a valid descriptor with bit 2 set, a write request gets fault 11 and a read request translates normally.
- R7: The effective DMA address has every bit at position `req_width_i` or above forced to 1. The bits below that position are kept. A width of 24 or more leaves the address unchanged.
- R8: A CPU write stores all 32 bits of a descriptor. A CPU read returns the stored word on `cpu_rdata_o` one cycle after the read is accepted, with the spare, modified and used bits unchanged.
- R9: When the CPU writes an entry in the same cycle that a DMA request looks up that entry, the response uses the value the entry held before the write.
- R10: DMA requests never change a descriptor. Modified and used bits change only through CPU writes.
- R11: Whenever `rsp_fault_o` is not 00, `rsp_addr_o`, `rsp_ci_o` and `rsp_bx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_en_i | input | 1 | CPU table access strobe |
| cpu_we_i | input | 1 | CPU access is a write (1) or a read (0) |
| cpu_idx_i | input | 11 | Descriptor index |
| cpu_wdata_i | input | 32 | Descriptor word to store |
| cpu_rdata_o | output | 32 | Descriptor word read, one cycle after the read |
| req_valid_i | input | 1 | DMA translation request |
| req_addr_i | input | 24 | DMA address |
| req_write_i | input | 1 | Request is a DMA write |
| req_width_i | input | 5 | Number of address lines on the requesting device |
| rsp_valid_o | output | 1 | Response valid |
| rsp_addr_o | output | 32 | Translated system bus address |
| rsp_ci_o | output | 1 | Cache inhibit attribute |
| rsp_bx_o | output | 1 | Full-block transfer attribute |
| rsp_fault_o | output | 2 | 00 none, 01 unused page, 10 illegal code, 11 write protect |

## Verification
The stored table is the only deep state. A corrupted entry shows up in two places. The next DMA request that hits it returns a wrong frame, a wrong attribute or a wrong fault, one cycle after the request. A CPU read of that entry also returns a wrong word, one cycle after the read.

A wrong pipeline register shows up on the very next response. A stray valid flag, or a stale offset or write flag, breaks the address, the latency or the protect decision in the cycle that follows. The bench first fills the whole table from the CPU side. It then replays random lookups, including narrow devices and collisions with CPU writes. Finally it reads entries back to confirm that DMA traffic left them untouched.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  localparam int DMA_AW    = 24;
  localparam int PAGE_BITS = 13;
  localparam int SYS_AW    = 32;
  localparam int IDX_W     = DMA_AW - PAGE_BITS;
  localparam int FRAME_W   = SYS_AW - PAGE_BITS;
  localparam int WID_W     = $clog2(DMA_AW + 1);

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [5:0]         spare;
    logic               ci;
    logic               bx;
    logic               mod;
    logic               used;
    logic               wp;
    logic [1:0]         dtype;
  } desc_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_UNUSED  = 2'b01,
    FLT_ILLEGAL = 2'b10,
    FLT_WPROT   = 2'b11
  } fault_e;
endpackage

// File: rtl/dxu_fold.sv
module dxu_fold
  import dxu_pkg::*;
(
  input  logic [DMA_AW-1:0] addr_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [DMA_AW-1:0] addr_o
);
  for (genvar i = 0; i < DMA_AW; i++) begin : g_bit
    assign addr_o[i] = addr_i[i] | (WID_W'(i) >= width_i);
  end
endmodule

// File: rtl/dxu_table.sv
module dxu_table
  import dxu_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          cpu_en_i,
  input  logic          cpu_we_i,
  input  logic [IW-1:0] cpu_idx_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic [31:0]   cpu_rdata_o,
  input  logic          lk_en_i,
  input  logic [IW-1:0] lk_idx_i,
  output desc_t         lk_desc_o
);
  localparam int DEPTH = 1 << IW;
  logic [31:0] mem [DEPTH];

  // Nonblocking reads see the pre-write value on a same-cycle collision.
  always_ff @(posedge clk_i) begin
    if (cpu_en_i && cpu_we_i) mem[cpu_idx_i] <= cpu_wdata_i;
    if (cpu_en_i && !cpu_we_i) cpu_rdata_o <= mem[cpu_idx_i];
    if (lk_en_i) lk_desc_o <= desc_t'(mem[lk_idx_i]);
  end
endmodule

// File: rtl/dxu_decode.sv
module dxu_decode
  import dxu_pkg::*;
(
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [PAGE_BITS-1:0] off_i,
  input  desc_t                desc_i,
  output logic [SYS_AW-1:0]    addr_o,
  output logic                 ci_o,
  output logic                 bx_o,
  output fault_e               fault_o
);
  logic unused_desc;
  assign unused_desc = ^{desc_i.spare, desc_i.mod, desc_i.used};

  always_comb begin
    fault_o = FLT_NONE;
    if (valid_i) begin
      if (desc_i.dtype[1])           fault_o = FLT_ILLEGAL;
      else if (!desc_i.dtype[0])     fault_o = FLT_UNUSED;
      else if (desc_i.wp && write_i) fault_o = FLT_WPROT;
    end
    if (valid_i && fault_o == FLT_NONE) begin
      addr_o = {desc_i.frame, off_i};
      ci_o   = desc_i.ci;
      bx_o   = desc_i.bx;
    end else begin
      addr_o = '0;
      ci_o   = 1'b0;
      bx_o   = 1'b0;
    end
  end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_en_i,
  input  logic                cpu_we_i,
  input  logic [IDX_W-1:0]    cpu_idx_i,
  input  logic [31:0]         cpu_wdata_i,
  output logic [31:0]         cpu_rdata_o,
  input  logic                req_valid_i,
  input  logic [DMA_AW-1:0]   req_addr_i,
  input  logic                req_write_i,
  input  logic [WID_W-1:0]    req_width_i,
  output logic                rsp_valid_o,
  output logic [SYS_AW-1:0]   rsp_addr_o,
  output logic                rsp_ci_o,
  output logic                rsp_bx_o,
  output logic [1:0]          rsp_fault_o
);
  logic [DMA_AW-1:0]    eff_addr;
  logic                 vld_q, wr_q;
  logic [PAGE_BITS-1:0] off_q;
  desc_t                desc_q;
  fault_e               fault;

  dxu_fold u_fold (
    .addr_i (req_addr_i),
    .width_i(req_width_i),
    .addr_o (eff_addr)
  );

  dxu_table u_table (
    .clk_i      (clk_i),
    .cpu_en_i   (cpu_en_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_idx_i  (cpu_idx_i),
    .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o),
    .lk_en_i    (req_valid_i),
    .lk_idx_i   (eff_addr[DMA_AW-1:PAGE_BITS]),
    .lk_desc_o  (desc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) begin
        wr_q  <= req_write_i;
        off_q <= eff_addr[PAGE_BITS-1:0];
      end
    end
  end

  dxu_decode u_decode (
    .valid_i(vld_q),
    .write_i(wr_q),
    .off_i  (off_q),
    .desc_i (desc_q),
    .addr_o (rsp_addr_o),
    .ci_o   (rsp_ci_o),
    .bx_o   (rsp_bx_o),
    .fault_o(fault)
  );

  assign rsp_valid_o = vld_q;
  assign rsp_fault_o = fault;
endmodule

// File: rtl/dxu_checker.sv
module dxu_checker
  import dxu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [DMA_AW-1:0] req_addr_i,
  input logic              req_write_i,
  input logic [WID_W-1:0]  req_width_i,
  input logic              rsp_valid_o,
  input logic [SYS_AW-1:0] rsp_addr_o,
  input logic              rsp_ci_o,
  input logic              rsp_bx_o,
  input logic [1:0]        rsp_fault_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !rsp_valid_o);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && rsp_fault_o == 2'b00);

  assert_offset_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_width_i >= WID_W'(PAGE_BITS) |=>
      rsp_fault_o != 2'b00 || rsp_addr_o[PAGE_BITS-1:0] == $past(req_addr_i[PAGE_BITS-1:0]));

  assert_wp_only_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> rsp_fault_o != 2'b11);

  assert_fault_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != 2'b00 |-> rsp_addr_o == '0 && !rsp_ci_o && !rsp_bx_o);
endmodule

bind dma_xlate_unit dxu_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_write_i(req_write_i),
  .req_width_i(req_width_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_addr_o (rsp_addr_o),
  .rsp_ci_o   (rsp_ci_o),
  .rsp_bx_o   (rsp_bx_o),
  .rsp_fault_o(rsp_fault_o)
);

// File: tb/sim_dma_xlate_unit.sv
module sim_dma_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_en_i = 1'b0, cpu_we_i = 1'b0;
  logic [10:0] cpu_idx_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [4:0]  req_width_i = 5'd24;
  logic        rsp_valid_o, rsp_ci_o, rsp_bx_o;
  logic [31:0] rsp_addr_o;
  logic [1:0]  rsp_fault_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [2048];

  always #2.5 clk = ~clk;

  dma_xlate_unit u0 (.*, .clk_i(clk));

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fold(logic [23:0] a, logic [4:0] w);
    logic [23:0] force_m;
    force_m = (w >= 5'd24) ? 24'h0 : (24'hFFFFFF << w);
    return a | force_m;
  endfunction

  // {valid, fault, ci, bx, addr}
  function automatic logic [63:0] expect_rsp(logic [23:0] a, logic [4:0] w, logic wr, logic [31:0] d);
    logic [23:0] e;
    logic [1:0]  f;
    e = fold(a, w);
    if (d[1])               f = 2'b10;
    else if (!d[0])         f = 2'b01;
    else if (d[2] && wr)    f = 2'b11;
    else                    f = 2'b00;
    if (f != 2'b00) return {27'd0, 1'b1, f, 2'b00, 32'd0};
    return {27'd0, 1'b1, f, d[6], d[5], d[31:13], e[12:0]};
  endfunction

  function automatic logic [63:0] got_rsp();
    return {27'd0, rsp_valid_o, rsp_fault_o, rsp_ci_o, rsp_bx_o, rsp_addr_o};
  endfunction

  task automatic cpu_write(logic [10:0] idx, logic [31:0] d);
    @(negedge clk);
    cpu_en_i = 1'b1; cpu_we_i = 1'b1; cpu_idx_i = idx; cpu_wdata_i = d;
    @(negedge clk);
    cpu_en_i = 1'b0; cpu_we_i = 1'b0;
    model[idx] = d;
  endtask

  task automatic cpu_read_check(string req, logic [10:0] idx);
    @(negedge clk);
    cpu_en_i = 1'b1; cpu_we_i = 1'b0; cpu_idx_i = idx;
    @(negedge clk);
    cpu_en_i = 1'b0;
    check(req, {32'd0, cpu_rdata_o}, {32'd0, model[idx]});
  endtask

  task automatic lookup(string req, logic [23:0] a, logic [4:0] w, logic wr);
    logic [23:0] e;
    e = fold(a, w);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_width_i = w; req_write_i = wr;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req, got_rsp(), expect_rsp(a, w, wr, model[e[23:13]]));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check("R1", {62'd0, rsp_valid_o, 1'b0} | {62'd0, rsp_fault_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", {61'd0, rsp_valid_o, rsp_fault_o}, 64'd0);

    // Fill the whole table; type field biased toward valid
    for (int i = 0; i < 2048; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[1:0] = ($urandom_range(0, 3) != 0) ? 2'b01 : 2'(($urandom_range(0, 2) == 0) ? 0 : $urandom_range(2, 3));
      cpu_write(11'(i), d);
    end

    // R8: readback incl. spare/mod/used bits
    cpu_write(11'd5, 32'hABCD_FF9B);
    cpu_read_check("R8", 11'd5);
    cpu_write(11'd6, 32'h0000_1F98);
    cpu_read_check("R8", 11'd6);

    // R3: valid page, attributes
    cpu_write(11'd10, 32'h1234_6061);
    lookup("R3", {11'd10, 13'h1ABC}, 5'd24, 1'b0);
    cpu_write(11'd11, 32'hFFFF_E001);
    lookup("R3", {11'd11, 13'h0001}, 5'd24, 1'b1);
    // R4: unused page, read and write
    cpu_write(11'd12, 32'hFFFF_E07C);
    lookup("R4", {11'd12, 13'h0}, 5'd24, 1'b0);
    lookup("R4", {11'd12, 13'h5}, 5'd24, 1'b1);
    // R5: illegal codes win over protect
    cpu_write(11'd13, 32'h8000_0006);
    lookup("R5", {11'd13, 13'h0}, 5'd24, 1'b1);
    cpu_write(11'd14, 32'h8000_0067);
    lookup("R5", {11'd14, 13'h7}, 5'd24, 1'b0);
    // R6: protect blocks writes, allows reads
    cpu_write(11'd15, 32'h4000_0045);
    lookup("R6", {11'd15, 13'h10}, 5'd24, 1'b1);
    lookup("R6", {11'd15, 13'h10}, 5'd24, 1'b0);
    // R7: narrow devices
    cpu_write(11'd2047, 32'h0ABC_0021);
    cpu_write(11'd2040, 32'h0DEF_0001);
    lookup("R7", 24'h00_1234, 5'd16, 1'b0);
    lookup("R7", 24'h00_0001, 5'd13, 1'b0);
    lookup("R7", 24'h00_0005, 5'd4, 1'b0);
    lookup("R7", 24'h00_0123, 5'd31, 1'b0);
    // R2: no request -> no response
    @(negedge clk);
    check("R2", {61'd0, rsp_valid_o, rsp_fault_o}, 64'd0);

    // R9: same-cycle CPU write and lookup of one entry
    begin
      logic [31:0] old_d;
      cpu_write(11'd20, 32'h5555_4001);
      old_d = model[20];
      @(negedge clk);
      cpu_en_i = 1'b1; cpu_we_i = 1'b1; cpu_idx_i = 11'd20; cpu_wdata_i = 32'h0000_0002;
      req_valid_i = 1'b1; req_addr_i = {11'd20, 13'h33}; req_width_i = 5'd24; req_write_i = 1'b0;
      @(negedge clk);
      cpu_en_i = 1'b0; cpu_we_i = 1'b0; req_valid_i = 1'b0;
      check("R9", got_rsp(), expect_rsp({11'd20, 13'h33}, 5'd24, 1'b0, old_d));
      model[20] = 32'h0000_0002;
      lookup("R9", {11'd20, 13'h33}, 5'd24, 1'b0);
    end

    // Random lookups (R2, R3..R7 via model)
    for (int k = 0; k < 1500; k++) begin
      logic [4:0] w;
      w = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(8, 23)) : 5'($urandom_range(24, 31));
      lookup("R3", 24'($urandom), w, 1'($urandom));
    end

    // R10: DMA traffic left descriptors unchanged
    for (int k = 0; k < 40; k++) cpu_read_check("R10", 11'($urandom));
    cpu_read_check("R10", 11'd2047);
    cpu_read_check("R10", 11'd15);

    // R11 directed: faulting entry with attribute bits set yields zeros
    cpu_write(11'd30, 32'hFFFF_E064);
    lookup("R11", {11'd30, 13'h1FFF}, 5'd24, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule